// File: doc/BRIEF.md
# Per-Core Boot Vector and Window Configuration Registers

This block holds the configuration state that a cluster of processor cores (virtual processors, VPs) needs at boot. Each VP owns a boot-vector register, from which the block derives that VP's exception base address, and a redirect pointer that names another VP. A register access always carries the index of the requesting VP. An access to the local section reaches the requester's own bank. An access to the remote section reaches the bank of the VP that the requester's redirect pointer names. One VP can therefore set the boot vector of any other VP before releasing it from reset.

A shared register places and enables an address window for a companion peripheral. A status register reports whether that peripheral is fitted, and a read-only count register returns the number of VPs minus one. The bus is a single-cycle register port. Writes take effect at the clock edge and reads return data in the same cycle.

Top module: `core_boot_regs`

## Requirements
- R1: After reset every VP's boot-vector register holds 0xBFC00000, every redirect pointer holds 0, and the window register holds 0 (window base 0, window disabled).
- R2: Local-section offsets (0x200 count, 0x204 pointer, 0x208 boot vector) address the requesting VP's bank. Remote-section offsets (0x300, 0x304, 0x308) address the bank of the VP named by the requester's current redirect pointer.
- R3: A write to a redirect pointer takes wdata bits 7:0. It is stored only when that value is less than NUM_CORES; otherwise the pointer keeps its previous value.
- R4: A write to a boot-vector register stores wdata ANDed with 0xFFFFF000 (bits 31:12 kept), and a read returns the stored value.
- R5: Each VP's 64-bit exception base output equals its stored boot vector sign-extended from bit 31. It is valid from the clock edge that stores the write.
- R6: A write to offset 0x000 stores wdata ANDed with 0xFFFFF001. win_base_o drives bits 31:12 of the stored value with bits 11:0 at zero, and win_en_o drives bit 0.
- R7: Offset 0x004 reads 1 when PERIPH_PRESENT is set. Offset 0x200 and offset 0x300 read NUM_CORES-1. Writes to these offsets change nothing.
- R8: Reads of any other offset return 0. Writes to any other offset change no register or output.
- R9: rdata_o carries read data combinationally while req_i is high and we_i is low. It is 0 in idle cycles and during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| core_i | input | CORE_W | Index of the requesting VP |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (same cycle) |
| xbase_o | output | NUM_CORES*64 | Exception base per VP; VP n in bits n*64+63:n*64 |
| win_base_o | output | 32 | Peripheral window base address |
| win_en_o | output | 1 | Peripheral window enable |

## Verification
The bench aims at the redirect path. It writes a pointer, then writes and reads through the remote section. A design that indexed the remote bank by the requester would corrupt the requester's own exception base. The bench writes out-of-range pointer values, including one whose upper bits are set but whose low byte is in range, so a design that checked the wrong width would either accept an illegal target or reject a legal one. Boot vectors with bit 31 clear and set expose a missing sign extension, and writes to unmapped or read-only offsets show up as stray changes on the exception base or window outputs.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned XB_W   = 64;

  localparam logic [ADDR_W-1:0] OFS_WIN   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h004;
  localparam logic [ADDR_W-1:0] SEC_LOCAL = 12'h200;
  localparam logic [ADDR_W-1:0] SEC_OTHER = 12'h300;
  localparam logic [ADDR_W-1:0] REG_CNT   = 12'h000;
  localparam logic [ADDR_W-1:0] REG_PTR   = 12'h004;
  localparam logic [ADDR_W-1:0] REG_VEC   = 12'h008;

  localparam logic [DATA_W-1:0] VEC_MASK  = 32'hFFFF_F000;
  localparam logic [DATA_W-1:0] VEC_RESET = 32'hBFC0_0000;
  localparam logic [DATA_W-1:0] WIN_MASK  = 32'hFFFF_F001;
  localparam int unsigned       PTR_FLD_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_WIN, SEL_STAT, SEL_CNT, SEL_PTR, SEL_VEC
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic remote;
  } dec_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '{sel: SEL_NONE, remote: 1'b0};
    if (addr_i == OFS_WIN)                  dec_o.sel = SEL_WIN;
    else if (addr_i == OFS_STAT)            dec_o.sel = SEL_STAT;
    else if (addr_i == SEC_LOCAL + REG_CNT) dec_o.sel = SEL_CNT;
    else if (addr_i == SEC_LOCAL + REG_PTR) dec_o.sel = SEL_PTR;
    else if (addr_i == SEC_LOCAL + REG_VEC) dec_o.sel = SEL_VEC;
    else if (addr_i == SEC_OTHER + REG_CNT) dec_o = '{sel: SEL_CNT, remote: 1'b1};
    else if (addr_i == SEC_OTHER + REG_PTR) dec_o = '{sel: SEL_PTR, remote: 1'b1};
    else if (addr_i == SEC_OTHER + REG_VEC) dec_o = '{sel: SEL_VEC, remote: 1'b1};
  end
endmodule

// File: rtl/cbr_core_bank.sv
module cbr_core_bank
  import cbr_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vec_we_i,
  input  logic              ptr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] vec_o,
  output logic [CORE_W-1:0] ptr_o,
  output logic [XB_W-1:0]   xbase_o
);
  logic [DATA_W-1:0] vec_q;
  logic [CORE_W-1:0] ptr_q;
  logic [PTR_FLD_W-1:0] ptr_fld;
  logic ptr_ok;

  assign ptr_fld = wdata_i[PTR_FLD_W-1:0];
  assign ptr_ok  = 32'(ptr_fld) < 32'(NUM_CORES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= VEC_RESET & VEC_MASK;
      ptr_q <= '0;
    end else begin
      if (vec_we_i)           vec_q <= wdata_i & VEC_MASK;
      if (ptr_we_i && ptr_ok) ptr_q <= ptr_fld[CORE_W-1:0];
    end
  end

  assign vec_o   = vec_q;
  assign ptr_o   = ptr_q;
  assign xbase_o = {{(XB_W-DATA_W){vec_q[DATA_W-1]}}, vec_q};

  p_ptr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_o) < 32'(NUM_CORES));
  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_i && 32'(wdata_i[PTR_FLD_W-1:0]) >= 32'(NUM_CORES)) |=> $stable(ptr_o));
  p_vec_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_i |=> (vec_o == ($past(wdata_i) & VEC_MASK)));
endmodule

// File: rtl/cbr_periph_win.sv
module cbr_periph_win
  import cbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reg_o,
  output logic [DATA_W-1:0] base_o,
  output logic              en_o
);
  logic [DATA_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_q <= '0;
    else if (we_i) win_q <= wdata_i & WIN_MASK;
  end

  assign reg_o  = win_q;
  assign base_o = win_q & VEC_MASK;
  assign en_o   = win_q[0];

  p_win_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_o == $past(wdata_i[0])) && (base_o == ($past(wdata_i) & VEC_MASK)));
endmodule

// File: rtl/core_boot_regs.sv
module core_boot_regs
  import cbr_pkg::*;
#(
  parameter int unsigned NUM_CORES      = 4,
  parameter bit          PERIPH_PRESENT = 1'b1,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [CORE_W-1:0]         core_i,
  input  logic [11:0]               addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_CORES*64-1:0]   xbase_o,
  output logic [31:0]               win_base_o,
  output logic                      win_en_o
);
  dec_t dec;
  logic core_ok, acc_wr, acc_rd;
  logic [CORE_W-1:0] tgt;
  logic [DATA_W-1:0] vec_a [NUM_CORES];
  logic [CORE_W-1:0] ptr_a [NUM_CORES];
  logic [DATA_W-1:0] win_reg;

  cbr_decode i_dec (.addr_i(addr_i), .dec_o(dec));

  assign core_ok = 32'(core_i) < 32'(NUM_CORES);
  assign acc_wr  = req_i && we_i && core_ok;
  assign acc_rd  = req_i && !we_i && core_ok;
  // remote section follows the requester's redirect pointer
  assign tgt     = dec.remote ? ptr_a[core_i] : core_i;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic sel_me;
    assign sel_me = acc_wr && (32'(tgt) == g);
    cbr_core_bank #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vec_we_i (sel_me && dec.sel == SEL_VEC),
      .ptr_we_i (sel_me && dec.sel == SEL_PTR),
      .wdata_i  (wdata_i),
      .vec_o    (vec_a[g]),
      .ptr_o    (ptr_a[g]),
      .xbase_o  (xbase_o[g*XB_W +: XB_W])
    );
  end

  cbr_periph_win i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc_wr && dec.sel == SEL_WIN),
    .wdata_i (wdata_i),
    .reg_o   (win_reg),
    .base_o  (win_base_o),
    .en_o    (win_en_o)
  );

  always_comb begin
    rdata_o = '0;
    if (acc_rd) begin
      unique case (dec.sel)
        SEL_WIN:  rdata_o = win_reg;
        SEL_STAT: rdata_o = {31'b0, PERIPH_PRESENT};
        SEL_CNT:  rdata_o = 32'(NUM_CORES - 1);
        SEL_PTR:  rdata_o = 32'(ptr_a[tgt]);
        SEL_VEC:  rdata_o = vec_a[tgt];
        default:  rdata_o = '0;
      endcase
    end
  end

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |-> (rdata_o == '0));
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dec.sel == SEL_NONE) |-> (rdata_o == '0));
  p_local_vec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && addr_i == SEC_LOCAL + REG_VEC) |-> (rdata_o == xbase_o[32'(core_i)*XB_W +: DATA_W]));
  p_xbase_sext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && dec.sel == SEL_VEC) |-> (xbase_o[32'(tgt)*XB_W + DATA_W +: XB_W-DATA_W] == {(XB_W-DATA_W){rdata_o[DATA_W-1]}}));
endmodule

// File: tb/test_core_boot_regs.sv
module test_core_boot_regs;
  localparam int NC = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [CW-1:0] core = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC*64-1:0] xbase;
  logic [31:0] win_base;
  logic win_en;

  int n_checks = 0, n_fail = 0;

  logic [31:0] m_vec [NC];
  int          m_ptr [NC];
  logic [31:0] m_win;

  always #10 clk = ~clk;

  core_boot_regs #(.NUM_CORES(NC)) i_core_boot_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .core_i(core),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .xbase_o(xbase),
    .win_base_o(win_base), .win_en_o(win_en)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic int tgt_of(int c, logic [11:0] a);
    return (a[11:8] == 4'h3) ? m_ptr[c] : c;
  endfunction

  function automatic logic [31:0] m_read(int c, logic [11:0] a);
    case (a)
      12'h000: return m_win;
      12'h004: return 32'd1;
      12'h200, 12'h300: return NC - 1;
      12'h204, 12'h304: return m_ptr[tgt_of(c, a)];
      12'h208, 12'h308: return m_vec[tgt_of(c, a)];
      default: return 32'd0;
    endcase
  endfunction

  function automatic void m_write(int c, logic [11:0] a, logic [31:0] d);
    int t;
    t = tgt_of(c, a);
    case (a)
      12'h000: m_win = d & 32'hFFFF_F001;
      12'h204, 12'h304: if ((d & 32'hFF) < NC) m_ptr[t] = d & 32'hFF;
      12'h208, 12'h308: m_vec[t] = d & 32'hFFFF_F000;
      default: ;
    endcase
  endfunction

  task automatic chk_outs(string rq);
    for (int i = 0; i < NC; i++)
      chk({rq, " xbase"}, xbase[i*64 +: 64], {{32{m_vec[i][31]}}, m_vec[i]});
    chk({rq, " win_base"}, win_base, m_win & 32'hFFFF_F000);
    chk({rq, " win_en"}, win_en, m_win[0]);
  endtask

  // one bus cycle; entered and left at a falling edge
  task automatic op(bit w, int c, logic [11:0] a, logic [31:0] d, string rq);
    req = 1'b1; we = w; core = CW'(c); addr = a; wdata = d;
    #1;
    chk({rq, " rdata"}, rdata, w ? 32'd0 : m_read(c, a));
    @(posedge clk);
    if (w) m_write(c, a, d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
    chk({rq, " idle rdata R9"}, rdata, 32'd0);
    chk_outs(rq);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin m_vec[i] = 32'hBFC0_0000; m_ptr[i] = 0; end
    m_win = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_outs("R1 reset");
    for (int i = 0; i < NC; i++) begin
      op(0, i, 12'h208, 0, "R1 reset vector");
      op(0, i, 12'h204, 0, "R1 reset pointer");
    end
    op(0, 0, 12'h000, 0, "R1 reset window");
    // R7 read-only registers
    op(0, 1, 12'h004, 0, "R7 status");
    op(0, 2, 12'h200, 0, "R7 count local");
    op(0, 3, 12'h300, 0, "R7 count remote");
    op(1, 0, 12'h200, 32'hFFFF_FFFF, "R7 count write ignored");
    op(1, 0, 12'h004, 32'h0, "R7 status write ignored");
    op(0, 0, 12'h004, 0, "R7 status after write");
    // R4 R5 local vectors, both signs
    op(1, 0, 12'h208, 32'h1234_5678, "R4 R5 vec pos");
    op(1, 1, 12'h208, 32'hFFFF_FFFF, "R4 R5 vec neg");
    op(1, 3, 12'h208, 32'h8000_0FFF, "R4 R5 vec top bit");
    op(0, 0, 12'h208, 0, "R4 readback");
    op(0, 1, 12'h208, 0, "R4 readback");
    // R2 redirect
    op(1, 0, 12'h204, 32'h2, "R2 set ptr");
    op(1, 0, 12'h308, 32'h0ABC_D123, "R2 remote vec write");
    op(0, 0, 12'h308, 0, "R2 remote vec read");
    op(0, 2, 12'h208, 0, "R2 target local view");
    op(0, 0, 12'h208, 0, "R2 requester untouched");
    op(1, 0, 12'h304, 32'h3, "R2 remote ptr write");
    op(0, 2, 12'h204, 0, "R2 target ptr moved");
    op(0, 0, 12'h304, 0, "R2 remote ptr read");
    // R3 range check
    op(1, 1, 12'h204, 32'h4, "R3 ptr out of range");
    op(0, 1, 12'h204, 0, "R3 ptr held");
    op(1, 1, 12'h204, 32'hFF, "R3 ptr ff");
    op(1, 1, 12'h204, 32'h105, "R3 ptr upper bits");
    op(0, 1, 12'h204, 0, "R3 ptr held 2");
    op(1, 1, 12'h204, 32'h103, "R3 ptr low byte ok");
    op(0, 1, 12'h204, 0, "R3 ptr accepted");
    op(1, 1, 12'h304, 32'h7, "R3 remote out of range");
    op(0, 3, 12'h204, 0, "R3 remote held");
    // R6 window
    op(1, 2, 12'h000, 32'hABCD_E7FF, "R6 window on");
    op(0, 0, 12'h000, 0, "R6 window read");
    op(1, 2, 12'h000, 32'h1357_9FFE, "R6 window off");
    // R8 unmapped
    op(1, 0, 12'h010, 32'hFFFF_FFFF, "R8 unmapped write");
    op(1, 0, 12'h20C, 32'hFFFF_FFFF, "R8 unmapped write sec");
    op(1, 0, 12'h20A, 32'hFFFF_FFFF, "R8 misaligned write");
    op(1, 0, 12'h108, 32'hFFFF_FFFF, "R8 wrong section write");
    op(0, 0, 12'h20C, 0, "R8 unmapped read");
    op(0, 1, 12'h00C, 0, "R8 unmapped read 2");
    op(0, 2, 12'h30A, 0, "R8 misaligned read");
    for (int i = 0; i < NC; i++) op(0, i, 12'h208, 0, "R8 vectors intact");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule